// File: doc/BRIEF.md
# Integer ALU Stage with Word and Half-Word Shift Modes

This block is the arithmetic and logic stage of an integer pipeline. It takes two operands, a carry input, a summary-overflow input and an operation context made of an operation code, a half-width (32-bit) mode flag and a signed flag. It computes an add-with-carry, a bitwise AND, OR or XOR, a left shift, or a logical or arithmetic right shift. It drives a full-width result and a carry output. The context is forwarded to the outputs untouched, so the next stage sees the same operation.

The shifts depend on the half-width flag. In full-width mode the shift amount has one bit more than the log of the width, so amounts from the width up to twice the width are legal and fully defined. In half-width mode the amount has one bit less, only the low half of operand a is shifted, and the upper half of the result is filled with zeros or with the half-word sign. The whole stage is combinational. A parameter selects an operator-based shifter or an explicit log-staged barrel shifter.

Top module: `wide_int_alu`

## Requirements
- R1: With op code 0 (add), {carry_o, result_o} equals the 65-bit sum a + b + carry_i, at full width, whatever the half and signed flags are.
- R2: With op codes 1, 2 and 3 (AND, OR, XOR), result_o is the bitwise AND, OR or XOR of the two full-width operands, and the half and signed flags have no effect.
- R3: With op code 4 (shift left) and the half flag set, the amount is b[5:0]. result_o[31:0] is the low 32 bits of a[31:0] shifted left by that amount, so amounts of 32 or more give zero, and result_o[63:32] is zero.
- R4: With op code 4 and the half flag clear, the amount is b[6:0]. result_o is the low 64 bits of a shifted left, so amounts of 64 to 127 give zero.
- R5: With op code 5 (shift right), the signed flag clear and the half flag set, result_o[31:0] is a[31:0] shifted right by b[5:0] with zero fill, and result_o[63:32] is zero.
- R6: With op code 5, the signed flag clear and the half flag clear, result_o is a shifted right by b[6:0] with zero fill.
- R7: With op code 5, the signed flag set and the half flag set, result_o[31:0] is a[31:0] shifted right by b[5:0] with copies of a[31] shifted in, and every bit of result_o[63:32] equals a[31].
- R8: With op code 5, the signed flag set and the half flag clear, result_o is a shifted right by b[6:0] with copies of a[63] shifted in, so amounts of 64 or more give all copies of a[63].
- R9: ctx_op_o, ctx_half_o and ctx_sgn_o always equal ctx_op_i, ctx_half_i and ctx_sgn_i.
- R10: For every op code other than 0, carry_o is 0. Op codes 6 and 7 are not recognised and give result_o of zero.
- R11: sum_ovf_i affects neither result_o nor carry_o.
- R12: The signed flag has no effect on a shift left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First operand; the value that is shifted |
| b_i | input | 64 | Second operand; its low bits give the shift amount |
| carry_i | input | 1 | Carry into the add |
| sum_ovf_i | input | 1 | Summary-overflow input, accepted and not used |
| ctx_op_i | input | 3 | Operation code |
| ctx_half_i | input | 1 | Half-width (32-bit) mode flag |
| ctx_sgn_i | input | 1 | Signed flag, selects arithmetic right shift |
| result_o | output | 64 | Operation result |
| carry_o | output | 1 | Carry out of the add, zero otherwise |
| ctx_op_o | output | 3 | Forwarded operation code |
| ctx_half_o | output | 1 | Forwarded half-width flag |
| ctx_sgn_o | output | 1 | Forwarded signed flag |

## Verification
Every output is combinational, so each result is due in the same cycle as the stimulus that produces it, with no register between input and output. The bench drives a new operand set on the falling clock edge, waits one nanosecond for the logic to settle and compares all outputs before the next rising edge. No check waits for a later cycle. To show that the summary-overflow input and the signed flag have no effect, the bench applies the same operands twice with only that input changed, and it compares both observations with the expected value.

// File: rtl/wide_int_alu_pkg.sv
package wide_int_alu_pkg;

   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OPC_ADD = 3'd0,
      OPC_AND = 3'd1,
      OPC_OR  = 3'd2,
      OPC_XOR = 3'd3,
      OPC_SHL = 3'd4,
      OPC_SHR = 3'd5
   } alu_opc_e;

   typedef enum logic [1:0] {
      LOGIC_AND = 2'd0,
      LOGIC_OR  = 2'd1,
      LOGIC_XOR = 2'd2
   } logic_fn_e;

endpackage

// File: rtl/wide_int_alu_adder.sv
module wide_int_alu_adder #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o
);
   logic [DATA_W:0] wide_sum;

   always_comb begin
      wide_sum = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
   end

   assign sum_o  = wide_sum[DATA_W-1:0];
   assign cout_o = wide_sum[DATA_W];
endmodule

// File: rtl/wide_int_alu_logic.sv
module wide_int_alu_logic
   import wide_int_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic_fn_e         fn_i,
   output logic [DATA_W-1:0] res_o
);
   always_comb begin
      unique case (fn_i)
         LOGIC_AND: res_o = a_i & b_i;
         LOGIC_OR:  res_o = a_i | b_i;
         LOGIC_XOR: res_o = a_i ^ b_i;
         default:   res_o = '0;
      endcase
   end
endmodule

// File: rtl/wide_int_alu_rshift.sv
module wide_int_alu_rshift #(
   parameter int W      = 64,
   parameter int AW     = 7,
   parameter bit STAGED = 1'b1
) (
   input  logic [W-1:0]  x_i,
   input  logic [AW-1:0] amt_i,
   input  logic          fill_i,
   output logic [W-1:0]  y_o
);
   generate
      if (STAGED) begin : g_staged
         logic [W-1:0] stage_v;
         always_comb begin
            stage_v = x_i;
            for (int k = 0; k < AW; k++) begin
               if (amt_i[k]) begin
                  if ((1 << k) >= W) begin
                     stage_v = {W{fill_i}};
                  end else begin
                     stage_v = (stage_v >> (1 << k)) |
                               (fill_i ? ~({W{1'b1}} >> (1 << k)) : {W{1'b0}});
                  end
               end
            end
         end
         assign y_o = stage_v;
      end else begin : g_operator
         assign y_o = fill_i ? ~((~x_i) >> amt_i) : (x_i >> amt_i);
      end
   endgenerate
endmodule

// File: rtl/wide_int_alu_shifter.sv
module wide_int_alu_shifter #(
   parameter int DATA_W = 64,
   parameter bit STAGED = 1'b1,
   parameter int SH_W   = $clog2(DATA_W) + 1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [SH_W-1:0]   amt_i,
   input  logic              left_i,
   input  logic              arith_i,
   input  logic              half_i,
   output logic [DATA_W-1:0] res_o
);
   localparam int HALF_W = DATA_W / 2;
   localparam int HSH_W  = SH_W - 1;

   logic [DATA_W-1:0] a_rev, full_in, full_out, full_out_rev, full_res;
   logic [HALF_W-1:0] h_rev, half_in, half_out, half_out_rev, half_lo;
   logic              sra_mode, full_fill, half_fill;

   assign sra_mode = arith_i & ~left_i;

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev_full
      assign a_rev[i]        = a_i[DATA_W-1-i];
      assign full_out_rev[i] = full_out[DATA_W-1-i];
   end

   for (genvar i = 0; i < HALF_W; i++) begin : g_rev_half
      assign h_rev[i]        = a_i[HALF_W-1-i];
      assign half_out_rev[i] = half_out[HALF_W-1-i];
   end

   assign full_in   = left_i ? a_rev : a_i;
   assign full_fill = sra_mode & a_i[DATA_W-1];
   assign half_in   = left_i ? h_rev : a_i[HALF_W-1:0];
   assign half_fill = sra_mode & a_i[HALF_W-1];

   wide_int_alu_rshift #(.W(DATA_W), .AW(SH_W), .STAGED(STAGED)) u_full (
      .x_i    (full_in),
      .amt_i  (amt_i),
      .fill_i (full_fill),
      .y_o    (full_out)
   );

   wide_int_alu_rshift #(.W(HALF_W), .AW(HSH_W), .STAGED(STAGED)) u_half (
      .x_i    (half_in),
      .amt_i  (amt_i[HSH_W-1:0]),
      .fill_i (half_fill),
      .y_o    (half_out)
   );

   assign full_res = left_i ? full_out_rev : full_out;
   assign half_lo  = left_i ? half_out_rev : half_out;

   always_comb begin
      if (half_i) begin
         res_o = {{HALF_W{half_fill}}, half_lo};
      end else begin
         res_o = full_res;
      end
   end
endmodule

// File: rtl/wide_int_alu.sv
module wide_int_alu
   import wide_int_alu_pkg::*;
#(
   parameter int DATA_W       = 64,
   parameter bit SHIFT_STAGED = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              carry_i,
   input  logic              sum_ovf_i,
   input  logic [OPC_W-1:0]  ctx_op_i,
   input  logic              ctx_half_i,
   input  logic              ctx_sgn_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o,
   output logic [OPC_W-1:0]  ctx_op_o,
   output logic              ctx_half_o,
   output logic              ctx_sgn_o
);
   localparam int SH_W = $clog2(DATA_W) + 1;

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("wide_int_alu: DATA_W must be a power of two of at least 8");
      end
   endgenerate

   logic [DATA_W-1:0] add_sum, logic_res, shift_res;
   logic              add_cout;
   logic_fn_e         logic_fn;
   alu_opc_e          opc;
   logic              unused_sum_ovf;

   assign opc            = alu_opc_e'(ctx_op_i);
   assign unused_sum_ovf = sum_ovf_i;

   always_comb begin
      case (opc)
         OPC_OR:  logic_fn = LOGIC_OR;
         OPC_XOR: logic_fn = LOGIC_XOR;
         default: logic_fn = LOGIC_AND;
      endcase
   end

   wide_int_alu_adder #(.DATA_W(DATA_W)) u_add (
      .a_i    (a_i),
      .b_i    (b_i),
      .cin_i  (carry_i),
      .sum_o  (add_sum),
      .cout_o (add_cout)
   );

   wide_int_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .a_i   (a_i),
      .b_i   (b_i),
      .fn_i  (logic_fn),
      .res_o (logic_res)
   );

   wide_int_alu_shifter #(.DATA_W(DATA_W), .STAGED(SHIFT_STAGED), .SH_W(SH_W)) u_shift (
      .a_i     (a_i),
      .amt_i   (b_i[SH_W-1:0]),
      .left_i  (opc == OPC_SHL),
      .arith_i (ctx_sgn_i),
      .half_i  (ctx_half_i),
      .res_o   (shift_res)
   );

   always_comb begin
      carry_o  = 1'b0;
      result_o = '0;
      case (opc)
         OPC_ADD: begin
            result_o = add_sum;
            carry_o  = add_cout;
         end
         OPC_AND, OPC_OR, OPC_XOR: result_o = logic_res;
         OPC_SHL, OPC_SHR:         result_o = shift_res;
         default:                  result_o = '0;
      endcase
   end

   assign ctx_op_o   = ctx_op_i;
   assign ctx_half_o = ctx_half_i;
   assign ctx_sgn_o  = ctx_sgn_i;
endmodule

// File: rtl/wide_int_alu_chk.sv
module wide_int_alu_chk #(
   parameter int DATA_W = 64
) (
   input logic [DATA_W-1:0] a_i,
   input logic [DATA_W-1:0] b_i,
   input logic              carry_i,
   input logic [2:0]        ctx_op_i,
   input logic              ctx_half_i,
   input logic              ctx_sgn_i,
   input logic [DATA_W-1:0] result_o,
   input logic              carry_o,
   input logic [2:0]        ctx_op_o,
   input logic              ctx_half_o,
   input logic              ctx_sgn_o
);
   localparam int HALF_W = DATA_W / 2;
   localparam int SH_W   = $clog2(DATA_W) + 1;

   logic known;
   assign known = !$isunknown({a_i, b_i, carry_i, ctx_op_i, ctx_half_i, ctx_sgn_i});

   always_comb begin
      if (known) begin
         a_r9_ctx_passthru: assert (ctx_op_o == ctx_op_i && ctx_half_o == ctx_half_i
                                    && ctx_sgn_o == ctx_sgn_i);
         if (ctx_op_i == 3'd0) begin
            a_r1_add_sum: assert ({carry_o, result_o} ==
                                  ({1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, carry_i}));
         end else begin
            a_r10_carry_zero: assert (carry_o == 1'b0);
         end
         if (ctx_op_i == 3'd3) begin
            a_r2_xor_inverse: assert ((result_o ^ a_i) == b_i);
         end
         if (ctx_op_i > 3'd5) begin
            a_r10_unknown_zero: assert (result_o == '0);
         end
         if (ctx_op_i == 3'd4 && ctx_half_i) begin
            a_r3_shl_half_upper: assert (result_o[DATA_W-1:HALF_W] == '0);
         end
         if (ctx_op_i == 3'd4 && !ctx_half_i && b_i[SH_W-1]) begin
            a_r4_shl_wide_amount: assert (result_o == '0);
         end
         if (ctx_op_i == 3'd5 && ctx_half_i && !ctx_sgn_i) begin
            a_r5_lsr_half_upper: assert (result_o[DATA_W-1:HALF_W] == '0);
         end
         if (ctx_op_i == 3'd5 && ctx_half_i && ctx_sgn_i) begin
            a_r7_asr_half_upper: assert (result_o[DATA_W-1:HALF_W] == {HALF_W{a_i[HALF_W-1]}});
         end
         if (ctx_op_i == 3'd5 && !ctx_half_i && ctx_sgn_i && b_i[SH_W-1]) begin
            a_r8_asr_wide_amount: assert (result_o == {DATA_W{a_i[DATA_W-1]}});
         end
      end
   end
endmodule

bind wide_int_alu wide_int_alu_chk #(.DATA_W(DATA_W)) chk_i (
   .a_i        (a_i),
   .b_i        (b_i),
   .carry_i    (carry_i),
   .ctx_op_i   (ctx_op_i),
   .ctx_half_i (ctx_half_i),
   .ctx_sgn_i  (ctx_sgn_i),
   .result_o   (result_o),
   .carry_o    (carry_o),
   .ctx_op_o   (ctx_op_o),
   .ctx_half_o (ctx_half_o),
   .ctx_sgn_o  (ctx_sgn_o)
);

// File: tb/wide_int_alu_tb_top.sv
module wide_int_alu_tb_top;
   logic        clk = 1'b0;
   logic [63:0] a, b;
   logic        cin, so;
   logic [2:0]  op;
   logic        half, sgn;
   logic [63:0] res;
   logic        cout;
   logic [2:0]  op_o;
   logic        half_o, sgn_o;

   int n_total = 0;
   int n_pass  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   wide_int_alu dut_i (
      .a_i (a), .b_i (b), .carry_i (cin), .sum_ovf_i (so),
      .ctx_op_i (op), .ctx_half_i (half), .ctx_sgn_i (sgn),
      .result_o (res), .carry_o (cout),
      .ctx_op_o (op_o), .ctx_half_o (half_o), .ctx_sgn_o (sgn_o)
   );

   function automatic logic [64:0] model(input logic [63:0] x, input logic [63:0] y,
                                         input logic ci, input logic [2:0] code,
                                         input logic hf, input logic sg);
      logic [64:0] r;
      logic [31:0] w;
      logic [63:0] d;
      int          n;
      r = '0;
      case (code)
         3'd0: r = {1'b0, x} + {1'b0, y} + {64'd0, ci};
         3'd1: r = {1'b0, x & y};
         3'd2: r = {1'b0, x | y};
         3'd3: r = {1'b0, x ^ y};
         3'd4: begin
            if (hf) begin
               n = int'(y[5:0]); w = x[31:0];
               for (int i = 0; i < n; i++) w = {w[30:0], 1'b0};
               r = {33'd0, w};
            end else begin
               n = int'(y[6:0]); d = x;
               for (int i = 0; i < n; i++) d = {d[62:0], 1'b0};
               r = {1'b0, d};
            end
         end
         3'd5: begin
            if (hf) begin
               n = int'(y[5:0]); w = x[31:0];
               for (int i = 0; i < n; i++) w = {sg & w[31], w[31:1]};
               r = {1'b0, {32{sg & x[31]}}, w};
            end else begin
               n = int'(y[6:0]); d = x;
               for (int i = 0; i < n; i++) d = {sg & d[63], d[63:1]};
               r = {1'b0, d};
            end
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string req_of(input logic [2:0] code, input logic hf, input logic sg);
      case (code)
         3'd0: return "R1";
         3'd1, 3'd2, 3'd3: return "R2";
         3'd4: return hf ? "R3" : "R4";
         3'd5: return hf ? (sg ? "R7" : "R5") : (sg ? "R8" : "R6");
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
      n_total++;
      if (act === exp) n_pass++;
      else $display("FAIL %s: actual %h expected %h", req, act, exp);
   endtask

   task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic ci,
                        input logic s, input logic [2:0] code, input logic hf,
                        input logic sg);
      @(negedge clk);
      a = x; b = y; cin = ci; so = s; op = code; half = hf; sgn = sg;
      #1;
   endtask

   task automatic run(input logic [63:0] x, input logic [63:0] y, input logic ci,
                      input logic [2:0] code, input logic hf, input logic sg);
      logic [64:0] exp;
      exp = model(x, y, ci, code, hf, sg);
      apply(x, y, ci, 1'b0, code, hf, sg);
      check(req_of(code, hf, sg), {cout, res}, exp);
      check("R9", {60'd0, op_o, half_o, sgn_o}, {60'd0, code, hf, sg});
      if (code != 3'd0) check("R10", {64'd0, cout}, 65'd0);
   endtask

   initial begin
      a = '0; b = '0; cin = 1'b0; so = 1'b0; op = '0; half = 1'b0; sgn = 1'b0;
      void'($urandom(32'd20240517));
      #1;
      // all-zero inputs: add of zeros
      check("R1", {cout, res}, 65'd0);

      // directed corner cases
      run('1, '1, 1'b1, 3'd0, 1'b0, 1'b0);                        // R1 full carry
      run('1, 64'd1, 1'b0, 3'd0, 1'b1, 1'b1);                     // R1 flags ignored
      run(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_1111, 1'b0, 3'd1, 1'b1, 1'b1); // R2
      run(64'hDEAD_BEEF_8000_0001, 64'd40, 1'b0, 3'd4, 1'b1, 1'b0); // R3 amount >= 32
      run(64'hDEAD_BEEF_8000_0001, 64'd31, 1'b0, 3'd4, 1'b1, 1'b0); // R3
      run(64'h1, 64'd63, 1'b0, 3'd4, 1'b0, 1'b0);                 // R4
      run('1, 64'd64, 1'b0, 3'd4, 1'b0, 1'b0);                    // R4 amount 64
      run(64'hFFFF_FFFF_F000_0000, 64'd4, 1'b0, 3'd5, 1'b1, 1'b0);  // R5
      run(64'h8000_0000_0000_0000, 64'd127, 1'b0, 3'd5, 1'b0, 1'b0); // R6
      run(64'h0000_0000_8000_0000, 64'd0, 1'b0, 3'd5, 1'b1, 1'b1);  // R7
      run(64'hFFFF_FFFF_7FFF_FFFF, 64'd33, 1'b0, 3'd5, 1'b1, 1'b1); // R7 positive half
      run(64'h8000_0000_0000_0001, 64'd100, 1'b0, 3'd5, 1'b0, 1'b1); // R8
      run(64'h1234, 64'h55, 1'b1, 3'd6, 1'b0, 1'b0);              // R10
      run(64'h1234, 64'h55, 1'b1, 3'd7, 1'b1, 1'b1);              // R10

      // R11: summary overflow has no effect
      for (int i = 0; i < 20; i++) begin
         logic [63:0] x, y; logic [2:0] c; logic ci, hf, sg; logic [64:0] e, r0;
         x = {$urandom, $urandom}; y = {$urandom, $urandom};
         c = 3'($urandom); ci = 1'($urandom); hf = 1'($urandom); sg = 1'($urandom);
         e = model(x, y, ci, c, hf, sg);
         apply(x, y, ci, 1'b0, c, hf, sg); r0 = {cout, res};
         apply(x, y, ci, 1'b1, c, hf, sg);
         check("R11", {cout, res}, r0);
         check("R11", {cout, res}, e);
      end

      // R12: signed flag has no effect on shift left
      for (int i = 0; i < 20; i++) begin
         logic [63:0] x, y; logic hf; logic [64:0] e, r0;
         x = {$urandom, $urandom}; y = {$urandom, $urandom}; hf = 1'($urandom);
         e = model(x, y, 1'b0, 3'd4, hf, 1'b0);
         apply(x, y, 1'b0, 1'b0, 3'd4, hf, 1'b0); r0 = {cout, res};
         apply(x, y, 1'b0, 1'b0, 3'd4, hf, 1'b1);
         check("R12", {cout, res}, r0);
         check("R12", {cout, res}, e);
      end

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [63:0] x, y;
         x = {$urandom, $urandom}; y = {$urandom, $urandom};
         if (i % 4 == 0) x = {x[31:0], 32'h8000_0000 | x[31:0]};
         run(x, y, 1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
      end

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_pass, n_total);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_total++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_pass, n_total);
         $finish;
      end
   end
endmodule